// File: doc/BRIEF.md
# Operand-Snooping Issue Queue

This block is a small pool of waiting slots that sits in front of one kind of execution unit in an out-of-order core. An operation enters a free slot with two source fields and the reorder-buffer tag of its own result. Each source field holds either a ready value or the reorder-buffer tag of the operation that will produce it. While a slot waits, it watches the result broadcast bus. When a broadcast tag matches a pending source, the slot copies that value into the source field.

Each cycle the block offers one slot whose two sources are both ready to the execution unit. When several slots qualify, the block offers the one that is oldest in reorder-buffer order. A slot that has been handed over stays occupied until its own result tag appears on the broadcast bus, and then it becomes free. A flush request removes every slot whose result tag is younger than a given tag. Age is measured forward from the current reorder-buffer head.

Top module: `rsv_station`

## Requirements
- R1: An issue request is accepted (`iss_accept`=1) only when `iss_valid`=1, `rob_free`=1, at least one slot is free (`rs_full`=0) and `flush_valid`=0. In every other case nothing is stored.
- R2: An accepted operation records its opcode and `iss_dst`. When it is later dispatched, `ex_op` and `ex_tag` show exactly those values, and a source issued as ready is presented unchanged.
- R3: A source issued as not ready holds the producer tag in the low 4 bits (`TAG_W`) of its operand field. The upper bits are ignored. When the broadcast bus shows that tag, the source takes `cdb_data`, and that value is what is later dispatched.
- R4: `ex_valid` is 1 only when some occupied, not yet dispatched slot has both sources ready at the start of the cycle.
- R5: When a source is issued not ready and its producer tag is broadcast in the same cycle, the new slot captures the broadcast value and becomes ready in the next cycle.
- R6: Among the candidate slots, the one offered has the smallest age, where age is (`dst` − `rob_head`) modulo 2^`TAG_W`. A slot moves to the executing state only in a cycle where `ex_valid` and `ex_ready` are both 1, and at most one slot does so per cycle.
- R7: A dispatched slot stays occupied until a broadcast carries its `dst` tag. From the next cycle it is free, and `rs_full` drops if the pool had been full.
- R8: When `flush_valid`=1, every slot whose age is greater than the age of `flush_tag` is freed at the next clock edge. Slots that are the same age or older keep all their state. During that cycle `ex_valid` is 0 and no issue is accepted.
- R9: After reset all slots are free: `ex_valid`=0 and `rs_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode of the issued operation |
| iss_a_rdy | input | 1 | Source A holds a value (1) or a tag (0) |
| iss_a | input | DATA_W | Source A value, or producer tag in the low TAG_W bits |
| iss_b_rdy | input | 1 | Source B holds a value (1) or a tag (0) |
| iss_b | input | DATA_W | Source B value, or producer tag in the low TAG_W bits |
| iss_dst | input | TAG_W | Reorder-buffer tag of the result |
| rob_free | input | 1 | Reorder buffer has a free slot |
| iss_accept | output | 1 | Issue taken this cycle |
| rs_full | output | 1 | All slots occupied |
| rob_head | input | TAG_W | Oldest live reorder-buffer tag, the age origin |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| ex_ready | input | 1 | Execution unit accepts an operation |
| ex_valid | output | 1 | An operation is offered |
| ex_op | output | OP_W | Offered opcode |
| ex_a | output | DATA_W | Offered source A |
| ex_b | output | DATA_W | Offered source B |
| ex_tag | output | TAG_W | Offered result tag |
| flush_valid | input | 1 | Flush request |
| flush_tag | input | TAG_W | Slots younger than this tag are removed |

## Verification
The hardest case to reach is one where the oldest-first choice is decided across the wrap of the tag space. That needs several slots to become ready in the same cycle while their tags straddle zero relative to `rob_head`. The bench gets there directly: it moves the tag counter near the top of the range, issues three operations that all wait on one external tag, and then broadcasts that tag once. The randomized phase adds flushes aimed at live tags, broadcasts of both executing and waiting tags, and issues that meet their own producer's broadcast in the same cycle. It checks all of this against a queue-based model on every clock.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2
  } slot_state_e;
endpackage

// File: rtl/rsv_entry.sv
`timescale 1ns/1ps
module rsv_entry
  import rsv_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   ld_op,
  input  logic              ld_a_rdy,
  input  logic [DATA_W-1:0] ld_a,
  input  logic              ld_b_rdy,
  input  logic [DATA_W-1:0] ld_b,
  input  logic [TAG_W-1:0]  ld_dst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              grant,
  input  logic              kill,
  output logic              busy,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] b,
  output logic [TAG_W-1:0]  dst
);
  slot_state_e st;
  logic a_rdy, b_rdy;

  // snoop match of a pending field against the broadcast tag
  function automatic logic tag_hit(input logic rdy, input logic [DATA_W-1:0] fld,
                                   input logic vld, input logic [TAG_W-1:0] t);
    return !rdy && vld && (fld[TAG_W-1:0] == t);
  endfunction

  // named events for the checks
  logic a_wake, b_wake, a_fwd, b_fwd, done_hit;
  assign a_wake   = (st == SLOT_WAIT) && tag_hit(a_rdy, a, cdb_valid, cdb_tag);
  assign b_wake   = (st == SLOT_WAIT) && tag_hit(b_rdy, b, cdb_valid, cdb_tag);
  assign a_fwd    = tag_hit(ld_a_rdy, ld_a, cdb_valid, cdb_tag);
  assign b_fwd    = tag_hit(ld_b_rdy, ld_b, cdb_valid, cdb_tag);
  assign done_hit = (st == SLOT_EXEC) && cdb_valid && (cdb_tag == dst);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= SLOT_FREE;
      a_rdy <= 1'b0;
      b_rdy <= 1'b0;
      op    <= '0;
      a     <= '0;
      b     <= '0;
      dst   <= '0;
    end else if (kill) begin
      st <= SLOT_FREE;
    end else if (load) begin
      st    <= SLOT_WAIT;
      op    <= ld_op;
      dst   <= ld_dst;
      a_rdy <= ld_a_rdy | a_fwd;
      b_rdy <= ld_b_rdy | b_fwd;
      a     <= a_fwd ? cdb_data : ld_a;
      b     <= b_fwd ? cdb_data : ld_b;
    end else begin
      case (st)
        SLOT_WAIT: begin
          if (a_wake) begin a_rdy <= 1'b1; a <= cdb_data; end
          if (b_wake) begin b_rdy <= 1'b1; b <= cdb_data; end
          if (grant) st <= SLOT_EXEC;
        end
        SLOT_EXEC: if (done_hit) st <= SLOT_FREE;
        default: ;
      endcase
    end
  end

  assign busy  = (st != SLOT_FREE);
  assign ready = (st == SLOT_WAIT) && a_rdy && b_rdy;

  AST_LOAD_INTO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy); // R1
  AST_GRANT_NEEDS_OPERANDS: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> (a_rdy && b_rdy && st == SLOT_WAIT)); // R4
  AST_WAKE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (a_wake && !kill) |=> (a_rdy && a == $past(cdb_data))); // R3
  AST_FWD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && b_fwd && !kill) |=> (b_rdy && b == $past(cdb_data))); // R5
  AST_FREE_ON_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_hit && !kill) |=> !busy); // R7
  AST_HOLD_UNTIL_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SLOT_EXEC && !done_hit && !kill) |=> (st == SLOT_EXEC && $stable(dst))); // R7
endmodule

// File: rtl/rsv_pick.sv
`timescale 1ns/1ps
module rsv_pick #(
  parameter int NUM_ENT = 4,
  parameter int TAG_W   = 4,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic [NUM_ENT-1:0]            req,
  input  logic [NUM_ENT-1:0][TAG_W-1:0] age,
  output logic                          any,
  output logic [IDX_W-1:0]              idx
);
  logic [TAG_W-1:0] best;

  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (req[i] && (!any || age[i] < best)) begin
        any  = 1'b1;
        idx  = IDX_W'(i);
        best = age[i];
      end
    end
  end
endmodule

// File: rtl/rsv_station.sv
`timescale 1ns/1ps
module rsv_station #(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int OP_W    = 4,
  localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic              iss_a_rdy,
  input  logic [DATA_W-1:0] iss_a,
  input  logic              iss_b_rdy,
  input  logic [DATA_W-1:0] iss_b,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic              rob_free,
  output logic              iss_accept,
  output logic              rs_full,
  input  logic [TAG_W-1:0]  rob_head,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              ex_ready,
  output logic              ex_valid,
  output logic [OP_W-1:0]   ex_op,
  output logic [DATA_W-1:0] ex_a,
  output logic [DATA_W-1:0] ex_b,
  output logic [TAG_W-1:0]  ex_tag,
  input  logic              flush_valid,
  input  logic [TAG_W-1:0]  flush_tag
);
  // distance of a tag from the reorder-buffer head, wraps with the tag space
  function automatic logic [TAG_W-1:0] rob_age(input logic [TAG_W-1:0] t,
                                               input logic [TAG_W-1:0] h);
    return t - h;
  endfunction

  logic [NUM_ENT-1:0]            busy, ready, load, grant, kill;
  logic [NUM_ENT-1:0][TAG_W-1:0] ages;
  logic [OP_W-1:0]   op_arr  [NUM_ENT];
  logic [DATA_W-1:0] a_arr   [NUM_ENT];
  logic [DATA_W-1:0] b_arr   [NUM_ENT];
  logic [TAG_W-1:0]  dst_arr [NUM_ENT];
  logic              any_ready, dispatch;
  logic [IDX_W-1:0]  sel_idx, alloc_idx;

  // lowest free slot takes the next issue
  always_comb begin
    alloc_idx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (!busy[i]) alloc_idx = IDX_W'(i);
  end

  assign rs_full    = &busy;
  assign iss_accept = iss_valid && rob_free && !rs_full && !flush_valid;
  assign ex_valid   = any_ready && !flush_valid;
  assign dispatch   = ex_valid && ex_ready;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
    assign ages[g]  = rob_age(dst_arr[g], rob_head);
    assign load[g]  = iss_accept && (alloc_idx == IDX_W'(g));
    assign grant[g] = dispatch && (sel_idx == IDX_W'(g));
    assign kill[g]  = flush_valid && busy[g] &&
                      (ages[g] > rob_age(flush_tag, rob_head));

    rsv_entry #(.DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W)) i_slot (
      .clk(clk), .rst_n(rst_n),
      .load(load[g]), .ld_op(iss_op),
      .ld_a_rdy(iss_a_rdy), .ld_a(iss_a),
      .ld_b_rdy(iss_b_rdy), .ld_b(iss_b),
      .ld_dst(iss_dst),
      .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
      .grant(grant[g]), .kill(kill[g]),
      .busy(busy[g]), .ready(ready[g]),
      .op(op_arr[g]), .a(a_arr[g]), .b(b_arr[g]), .dst(dst_arr[g])
    );

    AST_FLUSH_CLEARS_YOUNGER: assert property (@(posedge clk) disable iff (!rst_n)
      flush_valid |=> !(busy[g] &&
        (rob_age(dst_arr[g], $past(rob_head)) > rob_age($past(flush_tag), $past(rob_head))))); // R8
  end

  rsv_pick #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) i_pick (
    .req(ready), .age(ages), .any(any_ready), .idx(sel_idx)
  );

  assign ex_op  = op_arr[sel_idx];
  assign ex_a   = a_arr[sel_idx];
  assign ex_b   = b_arr[sel_idx];
  assign ex_tag = dst_arr[sel_idx];

  AST_ONE_DISPATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R6
  AST_NO_ACCEPT_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    iss_accept |-> (!rs_full && rob_free)); // R1
  AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> (!ex_valid && !iss_accept)); // R8
  AST_OFFER_IS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ex_valid |-> ready[sel_idx]); // R4
endmodule

// File: tb/test_rsv_station.sv
`timescale 1ns/1ps
module test_rsv_station;
  localparam int NE = 4, DW = 16, TW = 4, OW = 4, TD = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          iv = 0, ar = 0, br = 0, rf = 0, cv = 0, exr = 0, fv = 0;
  logic [OW-1:0] op = 0;
  logic [DW-1:0] av = 0, bv = 0, cdat = 0;
  logic [TW-1:0] dst = 0, head = 0, ctag = 0, ftag = 0;
  logic          iss_accept, rs_full, ex_valid;
  logic [OW-1:0] ex_op;
  logic [DW-1:0] ex_a, ex_b;
  logic [TW-1:0] ex_tag;

  rsv_station #(.NUM_ENT(NE), .DATA_W(DW), .TAG_W(TW), .OP_W(OW)) i_rsv_station (
    .clk(clk), .rst_n(rst_n),
    .iss_valid(iv), .iss_op(op), .iss_a_rdy(ar), .iss_a(av), .iss_b_rdy(br), .iss_b(bv),
    .iss_dst(dst), .rob_free(rf), .iss_accept(iss_accept), .rs_full(rs_full),
    .rob_head(head), .cdb_valid(cv), .cdb_tag(ctag), .cdb_data(cdat),
    .ex_ready(exr), .ex_valid(ex_valid), .ex_op(ex_op), .ex_a(ex_a), .ex_b(ex_b),
    .ex_tag(ex_tag), .flush_valid(fv), .flush_tag(ftag)
  );

  int total = 0, bad = 0;
  task automatic chk(bit ok, string rq, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  // ---------------- reference model ----------------
  typedef struct {int op; bit ra; int va; bit rb; int vb; int dst; bit disp;} m_ent_t;
  m_ent_t mq[$];
  int  next_tag = 0;
  bit  rf_block = 0;
  bit  p_acc, p_ev, p_full;
  int  p_idx;

  function automatic int agef(int t, int h);
    return (t - h + TD) % TD;
  endfunction

  task automatic drive_rob();
    int h, far;
    h = next_tag; far = 0;
    foreach (mq[i]) begin
      int back = (next_tag - mq[i].dst + TD) % TD;
      if (back > far) begin far = back; h = mq[i].dst; end
    end
    head = TW'(h);
    dst  = TW'(next_tag);
    rf   = !rf_block && (agef(next_tag, h) < 14);
  endtask

  task automatic predict();
    int best = TD;
    p_full = (mq.size() == NE);
    p_acc  = iv && rf && !p_full && !fv;
    p_idx  = -1;
    foreach (mq[i])
      if (!mq[i].disp && mq[i].ra && mq[i].rb && agef(mq[i].dst, int'(head)) < best) begin
        best  = agef(mq[i].dst, int'(head));
        p_idx = i;
      end
    p_ev = (p_idx >= 0) && !fv;
  endtask

  task automatic update();
    int dtag = -1;
    if (p_ev && exr) dtag = mq[p_idx].dst;
    if (fv) begin
      for (int i = mq.size() - 1; i >= 0; i--)
        if (agef(mq[i].dst, int'(head)) > agef(int'(ftag), int'(head))) mq.delete(i);
      next_tag = (int'(ftag) + 1) % TD;
    end
    if (cv) begin
      for (int i = mq.size() - 1; i >= 0; i--) begin
        if (mq[i].disp && mq[i].dst == int'(ctag)) mq.delete(i);
        else if (!mq[i].disp) begin
          if (!mq[i].ra && (mq[i].va % TD) == int'(ctag)) begin mq[i].ra = 1; mq[i].va = int'(cdat); end
          if (!mq[i].rb && (mq[i].vb % TD) == int'(ctag)) begin mq[i].rb = 1; mq[i].vb = int'(cdat); end
        end
      end
    end
    if (dtag >= 0)
      foreach (mq[i]) if (mq[i].dst == dtag) mq[i].disp = 1;
    if (p_acc) begin
      m_ent_t e;
      e.op = int'(op); e.ra = ar; e.va = int'(av); e.rb = br; e.vb = int'(bv);
      e.dst = next_tag; e.disp = 0;
      if (!e.ra && cv && (e.va % TD) == int'(ctag)) begin e.ra = 1; e.va = int'(cdat); end
      if (!e.rb && cv && (e.vb % TD) == int'(ctag)) begin e.rb = 1; e.vb = int'(cdat); end
      mq.push_back(e);
      next_tag = (next_tag + 1) % TD;
    end
  endtask

  // one clock: drive at negedge, compare mid-low phase, model steps at posedge
  task automatic cyc();
    drive_rob();
    #5;
    predict();
    chk(iss_accept == p_acc, "R1 issue accept", int'(iss_accept), int'(p_acc));
    chk(rs_full == p_full, "R7 pool full", int'(rs_full), int'(p_full));
    chk(ex_valid == p_ev, "R4/R8 ex_valid", int'(ex_valid), int'(p_ev));
    if (p_ev && ex_valid) begin
      chk(int'(ex_tag) == mq[p_idx].dst, "R6 oldest tag", int'(ex_tag), mq[p_idx].dst);
      chk(int'(ex_op) == mq[p_idx].op, "R2 opcode", int'(ex_op), mq[p_idx].op);
      chk(int'(ex_a) == mq[p_idx].va, "R3 operand a", int'(ex_a), mq[p_idx].va);
      chk(int'(ex_b) == mq[p_idx].vb, "R3 operand b", int'(ex_b), mq[p_idx].vb);
    end
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    iv = 0; cv = 0; fv = 0; exr = 0;
  endtask

  task automatic issue(int o, bit r1, int v1, bit r2, int v2);
    iv = 1; op = OW'(o); ar = r1; av = DW'(v1); br = r2; bv = DW'(v2);
  endtask

  task automatic bcast(int t, int d);
    cv = 1; ctag = TW'(t); cdat = DW'(d);
  endtask

  int t0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(ex_valid == 0, "R9 reset ex_valid", int'(ex_valid), 0);
    chk(rs_full == 0, "R9 reset rs_full", int'(rs_full), 0);

    // R2: both ready, held while unit busy, then dispatched and released
    idle(); issue(5, 1, 100, 1, 200); cyc();
    idle(); cyc(); cyc();
    #1 chk(ex_valid == 1 && ex_a == 100, "R2 ready operands kept", int'(ex_a), 100);
    exr = 1; cyc();
    idle(); bcast(0, 7); cyc();
    idle(); cyc();

    // R3: wait on an external tag, junk in upper bits
    issue(2, 0, 16'hABC9, 1, 3); cyc();
    idle(); cyc(); cyc();
    bcast(9, 16'h1234); cyc();
    idle();
    #1 chk(ex_valid == 1 && ex_a == 16'h1234, "R3 snooped value", int'(ex_a), 16'h1234);
    exr = 1; cyc();
    idle(); bcast(1, 0); cyc(); idle();

    // R5: issue meets its producer's broadcast in the same cycle
    issue(6, 1, 11, 0, 16'h000B); bcast(11, 16'h5555); cyc();
    idle();
    #1 chk(ex_valid == 1 && ex_b == 16'h5555, "R5 same-cycle forward", int'(ex_b), 16'h5555);
    exr = 1; cyc();
    idle(); bcast(2, 0); cyc(); idle(); cyc();

    // R6: three slots wake together with tags across the wrap
    next_tag = 14;
    for (int k = 0; k < 3; k++) begin issue(k, 0, 8, 1, k); cyc(); end
    idle(); cyc();
    bcast(8, 16'h0F0F); cyc();
    idle(); exr = 1;
    #1 chk(ex_tag == 14, "R6 oldest across wrap", int'(ex_tag), 14);
    cyc(); cyc(); cyc();
    idle(); bcast(15, 0); cyc(); bcast(14, 0); cyc(); bcast(0, 0); cyc(); idle(); cyc();

    // R1/R7: fill the pool, refuse a fifth, refuse when reorder buffer is full
    for (int k = 0; k < 5; k++) begin issue(k, 0, 6, 1, 0); cyc(); end
    #1 chk(rs_full == 1, "R7 pool full after four", int'(rs_full), 1);
    idle(); rf_block = 1; issue(1, 1, 1, 1, 1); cyc(); rf_block = 0;

    // R8: flush keeps the two oldest
    idle(); fv = 1; ftag = TW'((next_tag + TD - 3) % TD); cyc();
    idle();
    #1 chk(rs_full == 0, "R8 flush freed slots", int'(rs_full), 0);
    bcast(6, 42); cyc(); idle(); exr = 1; cyc(); cyc();
    idle();
    foreach (mq[i]) begin bcast(mq[i].dst, 0); cyc(); end
    idle(); cyc();

    // randomized traffic
    for (int n = 0; n < 6000; n++) begin
      idle();
      exr = ($urandom_range(0, 9) < 7);
      if ($urandom_range(0, 9) < 7) begin
        issue($urandom_range(0, 15), 0, 0, 0, 0);
        for (int s = 0; s < 2; s++) begin
          bit r = $urandom_range(0, 1);
          int v;
          if (r) v = $urandom_range(0, 65535);
          else begin
            if (mq.size() > 0 && $urandom_range(0, 9) < 6) t0 = mq[$urandom_range(0, mq.size() - 1)].dst;
            else t0 = $urandom_range(0, 15);
            v = ($urandom_range(0, 4095) << 4) | t0;
          end
          if (s == 0) begin ar = r; av = DW'(v); end else begin br = r; bv = DW'(v); end
        end
      end
      if ($urandom_range(0, 1) == 1) begin
        t0 = $urandom_range(0, 15);
        foreach (mq[i]) if (mq[i].disp && $urandom_range(0, 2) != 0) t0 = mq[i].dst;
        bcast(t0, $urandom_range(0, 65535));
      end
      if (mq.size() > 0 && $urandom_range(0, 99) < 4) begin
        fv = 1; ftag = TW'(mq[$urandom_range(0, mq.size() - 1)].dst);
      end
      cyc();
    end
    idle(); cyc();
    finish_run();
  end
endmodule